// File: doc/BRIEF.md
# Negacyclic Coefficient Weighting Unit

This unit applies the per-coefficient weighting that makes a cyclic number-theoretic transform compute a product reduced modulo x^N+1 over Z_Q. Two coefficient streams, one per operand polynomial, enter together at one coefficient of each per cycle. In the forward (pre) mode the k-th accepted coefficient of both streams is multiplied by PHI^k mod Q. In the inverse (post) mode the k-th coefficient is multiplied by N^-1 · PHI^-k mod Q. This folds the inverse-transform scale into the same multiply.

The unit holds no weight table. It keeps one running weight register and advances it with a single modular multiply for each accepted coefficient. A `start_i` pulse begins a run and samples the mode. `valid_i` then marks the coefficients to weight, and gaps in `valid_i` pause the sequence. `done_o` rises together with the N-th weighted output. The constants PHI^-1 and N^-1 are derived at elaboration from Q, N and PHI.

Top module: `nc_scaler`

## Requirements
- R1: In pre mode (`mode_i`=0 at start), the k-th accepted pair (k = 0..N-1) produces `a_o` = a·PHI^k mod Q and `b_o` = b·PHI^k mod Q in the same output cycle.
- R2: In post mode (`mode_i`=1 at start), the k-th accepted pair produces a·N^-1·PHI^-k mod Q and b·N^-1·PHI^-k mod Q, with the inverses taken mod Q.
- R3: In pre mode the first accepted coefficient is weighted by 1, so an input of Q or above leaves as its residue mod Q.
- R4: Every output coefficient lies in 0..Q-1 for any W-bit input, where W = ceil(log2 Q).
- R5: `valid_o` and the data appear exactly one cycle after an accepted `valid_i`. A cycle without `valid_i` inside a run does not advance the coefficient index.
- R6: `start_i` clears the index and loads the initial weight for the sampled mode, and it may restart a run in progress. A `valid_i` in the same cycle as `start_i` is not accepted.
- R7: `done_o` rises in the cycle of the N-th output and stays high until the next `start_i`. While no run is active, `valid_i` is ignored and `valid_o` stays low.
- R8: During and right after reset, `valid_o` and `done_o` are low and `a_o`, `b_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run; samples mode_i |
| mode_i | input | 1 | 0 = pre weighting by PHI^k, 1 = post weighting by N^-1·PHI^-k |
| valid_i | input | 1 | Coefficient pair present on a_i and b_i |
| a_i | input | W | Coefficient of the first polynomial |
| b_i | input | W | Coefficient of the second polynomial |
| valid_o | output | 1 | Weighted pair present on a_o and b_o |
| a_o | output | W | Weighted coefficient of the first polynomial |
| b_o | output | W | Weighted coefficient of the second polynomial |
| done_o | output | 1 | N coefficients weighted since the last start |

## Verification
The assertions check on every cycle the cycle-level rules. An output needs an accepted input one cycle earlier. Inputs outside a run are dropped, and outputs stay below Q. A start clears `done_o`, `done_o` holds until the next start, and it rises only together with an output. The arithmetic itself can only be shown by the bench scenarios. The bench compares each pair against a model that builds PHI^k by repeated multiplication, in both modes and with gaps in `valid_i`. It also applies inputs at or above Q, restarts a run partway through with the other mode, and raises `valid_i` in the same cycle as `start_i`.

// File: rtl/nc_scaler_pkg.sv
package nc_scaler_pkg;

  typedef enum logic {
    MODE_PRE  = 1'b0,
    MODE_POST = 1'b1
  } scale_mode_e;

  // b^e mod m, elaboration-time only
  function automatic longint unsigned pow_mod(longint unsigned b, longint unsigned e,
                                              longint unsigned m);
    longint unsigned r;
    longint unsigned x;
    longint unsigned k;
    r = 1;
    x = b % m;
    k = e;
    for (int i = 0; i < 40; i++) begin
      if (k[0]) r = (r * x) % m;
      x = (x * x) % m;
      k = k >> 1;
    end
    return r;
  endfunction

  // inverse through Fermat, Q prime
  function automatic longint unsigned inv_mod(longint unsigned v, longint unsigned m);
    return pow_mod(v, m - 2, m);
  endfunction

endpackage

// File: rtl/nc_modmul.sv
module nc_modmul #(
  parameter int unsigned Q = 12289,
  parameter int unsigned W = 14
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] p_o
);
  localparam int unsigned PW   = 2 * W;
  localparam int unsigned MU_W = W + 2;
  localparam int unsigned EW   = PW + MU_W;
  localparam int unsigned RW   = PW + 2;
  localparam longint unsigned MU = (longint'(1) << PW) / Q;

  logic [PW-1:0]   prod;
  logic [EW-1:0]   est;
  logic [MU_W-1:0] quo;
  logic [RW-1:0]   r0, r1, r2;

  // Barrett: quotient estimate is low by at most two
  always_comb begin
    prod = PW'(x_i) * PW'(y_i);
    est  = EW'(prod) * EW'(MU);
    quo  = est[EW-1:PW];
    r0   = RW'(prod) - RW'(quo) * RW'(Q);
    r1   = (r0 >= RW'(Q)) ? r0 - RW'(Q) : r0;
    r2   = (r1 >= RW'(Q)) ? r1 - RW'(Q) : r1;
    p_o  = r2[W-1:0];
  end

endmodule

// File: rtl/nc_weight_seq.sv
module nc_weight_seq
  import nc_scaler_pkg::*;
#(
  parameter int unsigned Q       = 12289,
  parameter int unsigned N       = 512,
  parameter int unsigned W       = 14,
  parameter logic [W-1:0] STEP_F = '0,
  parameter logic [W-1:0] STEP_R = '0,
  parameter logic [W-1:0] INIT_R = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic         step_i,
  output logic [W-1:0] weight_o,
  output logic         active_o,
  output logic         done_o
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  scale_mode_e       mode_q;
  logic [IDX_W-1:0]  idx_q;
  logic [W-1:0]      w_q, w_next, step_k;
  logic              active_q, done_q;

  assign step_k = (mode_q == MODE_POST) ? STEP_R : STEP_F;

  nc_modmul #(.Q(Q), .W(W)) u_wmul (
    .x_i (w_q),
    .y_i (step_k),
    .p_o (w_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_PRE;
      idx_q    <= '0;
      w_q      <= W'(1);
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (start_i) begin
      mode_q   <= scale_mode_e'(mode_i);
      idx_q    <= '0;
      w_q      <= mode_i ? INIT_R : W'(1);
      active_q <= 1'b1;
      done_q   <= 1'b0;
    end else if (step_i && active_q) begin
      w_q   <= w_next;
      idx_q <= idx_q + IDX_W'(1);
      if (idx_q == LAST) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end

  assign weight_o = w_q;
  assign active_o = active_q;
  assign done_o   = done_q;

endmodule

// File: rtl/nc_lane.sv
module nc_lane #(
  parameter int unsigned Q = 12289,
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         take_i,
  input  logic [W-1:0] coef_i,
  input  logic [W-1:0] weight_i,
  output logic [W-1:0] coef_o
);
  logic [W-1:0] prod, data_q;

  nc_modmul #(.Q(Q), .W(W)) u_mul (
    .x_i (coef_i),
    .y_i (weight_i),
    .p_o (prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_q <= '0;
    else if (take_i) data_q <= prod;
  end

  assign coef_o = data_q;

endmodule

// File: rtl/nc_scaler.sv
module nc_scaler
  import nc_scaler_pkg::*;
#(
  parameter int unsigned Q   = 12289,
  parameter int unsigned N   = 512,
  parameter int unsigned PHI = 10302,
  localparam int unsigned W  = $clog2(Q)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic         valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         done_o
);
  localparam int unsigned LANES = 2;
  localparam logic [W-1:0] PHI_F = W'(longint'(PHI) % longint'(Q));
  localparam logic [W-1:0] PHI_R = W'(inv_mod(longint'(PHI), longint'(Q)));
  localparam logic [W-1:0] N_INV = W'(inv_mod(longint'(N) % longint'(Q), longint'(Q)));

  logic         take, run_active, valid_q;
  logic [W-1:0] weight;
  logic [W-1:0] lane_in  [LANES];
  logic [W-1:0] lane_out [LANES];

  assign take = valid_i && run_active && !start_i;

  nc_weight_seq #(
    .Q(Q), .N(N), .W(W),
    .STEP_F(PHI_F), .STEP_R(PHI_R), .INIT_R(N_INV)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .step_i   (take),
    .weight_o (weight),
    .active_o (run_active),
    .done_o   (done_o)
  );

  assign lane_in[0] = a_i;
  assign lane_in[1] = b_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    nc_lane #(.Q(Q), .W(W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .take_i   (take),
      .coef_i   (lane_in[g]),
      .weight_i (weight),
      .coef_o   (lane_out[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= take;
  end

  assign valid_o = valid_q;
  assign a_o     = lane_out[0];
  assign b_o     = lane_out[1];

endmodule

// File: rtl/nc_scaler_chk.sv
module nc_scaler_chk #(
  parameter int unsigned Q = 12289,
  parameter int unsigned W = 14
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         valid_i,
  input logic         active_i,
  input logic         valid_o,
  input logic [W-1:0] a_o,
  input logic [W-1:0] b_o,
  input logic         done_o
);
  // R5
  out_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i && !start_i));

  // R7
  idle_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !active_i && !start_i) |=> !valid_o);

  // R4
  residue_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (a_o < W'(Q)) && (b_o < W'(Q)));

  // R6
  start_clears_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);

  // R7
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  // R7
  done_with_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> valid_o);

endmodule

bind nc_scaler nc_scaler_chk #(.Q(Q), .W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .valid_i  (valid_i),
  .active_i (run_active),
  .valid_o  (valid_o),
  .a_o      (a_o),
  .b_o      (b_o),
  .done_o   (done_o)
);

// File: tb/nc_scaler_tb.sv
module nc_scaler_tb;
  localparam int unsigned Q   = 12289;
  localparam int unsigned N   = 512;
  localparam int unsigned PHI = 10302;
  localparam int unsigned W   = 14;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, mode = 1'b0, vin = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         vout, done;
  logic [W-1:0] a_out, b_out;

  int unsigned n_chk = 0, n_bad = 0;
  longint unsigned phi_inv, n_inv;
  longint unsigned m_w;
  int unsigned     m_cnt;
  bit              m_busy, m_done, m_post;

  always #2 clk = ~clk;

  nc_scaler #(.Q(Q), .N(N), .PHI(PHI)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .valid_i(vin), .a_i(a_in), .b_i(b_in),
    .valid_o(vout), .a_o(a_out), .b_o(b_out), .done_o(done)
  );

  function automatic longint unsigned find_inv(longint unsigned v);
    for (longint unsigned x = 1; x < Q; x++)
      if ((v * x) % Q == 1) return x;
    return 0;
  endfunction

  task automatic chk(input string req, input longint unsigned got, input longint unsigned exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic cyc(input bit s, input bit m, input bit v,
                     input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    bit ev;
    longint unsigned ea, eb;
    @(negedge clk);
    start = s; mode = m; vin = v; a_in = a; b_in = b;
    ev = 0; ea = 0; eb = 0;
    if (s) begin
      m_busy = 1; m_done = 0; m_cnt = 0; m_post = m;
      m_w = m ? n_inv : 1;
    end else if (v && m_busy) begin
      ev = 1;
      ea = (longint'(a) * m_w) % Q;
      eb = (longint'(b) * m_w) % Q;
      m_w = (m_w * (m_post ? phi_inv : longint'(PHI))) % Q;
      m_cnt++;
      if (m_cnt == N) begin m_busy = 0; m_done = 1; end
    end
    @(posedge clk); #1;
    chk(ev ? "R5" : "R7", vout, ev);
    if (ev) begin
      chk(req, a_out, ea);
      chk(req, b_out, eb);
      chk("R4", a_out < Q && b_out < Q, 1);
    end
    chk("R7", done, m_done);
  endtask

  function automatic logic [W-1:0] rnd_any();
    return W'($urandom_range(0, (1 << W) - 1));
  endfunction

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20201));
    phi_inv = find_inv(PHI);
    n_inv   = find_inv(N % Q);
    m_busy = 0; m_done = 0; m_cnt = 0; m_w = 1; m_post = 0;

    // R8 reset state
    @(posedge clk); #1;
    chk("R8", vout, 0); chk("R8", done, 0); chk("R8", a_out, 0); chk("R8", b_out, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R8", vout, 0); chk("R8", done, 0);

    // R7 no run yet: valid ignored
    cyc(0, 0, 1, 14'd77, 14'd91, "R7");

    // R6 start with valid in same cycle; pre mode
    cyc(1, 0, 1, 14'd5, 14'd6, "R6");
    // R3 first coefficient above Q and all-ones
    cyc(0, 0, 1, 14'(Q + 5), 14'h3FFF, "R3");
    for (int i = 1; i < N; i++) begin
      if (i == 7) cyc(0, 0, 1, 14'(Q - 1), 14'd0, "R1");
      else        cyc(0, 0, 1, rnd_any(), rnd_any(), "R1");
    end
    // R7 run over: valid ignored, done held
    cyc(0, 0, 1, 14'd100, 14'd200, "R7");
    cyc(0, 1, 1, 14'd3, 14'd4, "R7");

    // R2 post mode, full run with corner values
    cyc(1, 1, 0, 14'd0, 14'd0, "R6");
    for (int i = 0; i < N; i++) begin
      if (i == 0)      cyc(0, 0, 1, 14'(Q - 1), 14'd1, "R2");
      else if (i == 1) cyc(0, 0, 1, 14'd0, 14'(Q), "R2");
      else             cyc(0, 0, 1, rnd_any(), rnd_any(), "R2");
    end

    // R5 pre mode with gaps; restart mid-run (R6) into post mode
    cyc(1, 0, 0, 14'd0, 14'd0, "R6");
    for (int i = 0; i < 150; i++)
      cyc(0, 0, ($urandom_range(0, 3) != 0), rnd_any(), rnd_any(), "R5");
    cyc(1, 1, 1, 14'd9, 14'd9, "R6");
    while (m_busy) begin
      cyc(0, 0, ($urandom_range(0, 2) != 0), rnd_any(), rnd_any(), "R6");
    end
    cyc(0, 0, 0, 14'd0, 14'd0, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule